// File: doc/BRIEF.md
# Parking Occupancy Ones Counter

This block reports how many of forty parking slots are taken. Each slot contributes one occupancy bit, and the block counts the bits at 1 wherever they sit in the input vector. It presents the total in two forms: a binary number, and a pair of BCD digits that a separate seven-segment decoder can show. A flag goes high when the lot has no free slot left.

The logic is purely combinational and built from repeated parts. A small counting element covers four slots, and ten copies of it cover the lot. A balanced adder tree sums their partial counts. A final stage splits the binary total into its tens and units digits. The slot count and the leaf width are parameters, so the same structure fits other lot sizes.

Top module: `occ_slot_counter`

## Requirements
- R1: Input bit `slot_occ[i]` carries the state of slot i; 1 means occupied and 0 means free. Every one of the 40 bits takes part in the count.
- R2: `occ_count` equals the number of bits of `slot_occ` at 1, whatever their positions, as an unsigned 6-bit binary value from 0 to 40.
- R3: `lot_full` is 1 exactly when all 40 bits of `slot_occ` are 1, and it is 0 for every other pattern, including 39 occupied slots.
- R4: With every slot free, `occ_count` is 0, both digits are 0 and `lot_full` is 0.
- R5: `occ_tens` holds the tens digit of the count as 4-bit BCD, from 0 to 4.
- R6: `occ_units` holds the units digit of the count as 4-bit BCD, from 0 to 9, and 10*tens + units equals `occ_count`.
- R7: All outputs depend only on the present value of `slot_occ`. They settle within the same clock period as an input change, with no clock and no stored state.
- R8: Each four-slot leaf yields a count from 0 to 4, and the tree total never exceeds the slot count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slot_occ | input | 40 | Occupancy bit per slot, 1 = occupied |
| occ_count | output | 6 | Binary number of occupied slots |
| occ_tens | output | 4 | BCD tens digit of the count |
| occ_units | output | 4 | BCD units digit of the count |
| lot_full | output | 1 | High when every slot is occupied |

## Verification
The hardest cases to reach are the ones at the very top of the range. Uniform random vectors almost never contain 39 or 40 ones, so the full flag, the tens digit 4 and the sum through the widest tree node would see no traffic. The stimulus therefore walks a single free slot through every position of an otherwise full lot. It also fills the lot one slot at a time as a thermometer, and mixes in dense patterns made by ORing random words together, alongside sparse and uniform random vectors. The expected count is a plain popcount loop in the bench.

// File: rtl/occ_pkg.sv
// Package occ_pkg
// Shared types for the occupancy counter.
// Assumes: display digits are 4-bit BCD.
package occ_pkg;
    localparam int BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_digit_t;
endpackage

// File: rtl/occ_leaf_count.sv
// Module occ_leaf_count
// Counts the ones among LEAF_SLOTS occupancy bits.
// Assumes: LEAF_SLOTS is small (a few bits), so a ripple sum is shallow.
module occ_leaf_count #(
    parameter int LEAF_SLOTS = 4,
    localparam int CW = $clog2(LEAF_SLOTS + 1)
) (
    input  logic [LEAF_SLOTS-1:0] bits_in,
    output logic [CW-1:0]         leaf_cnt
);

    // Purpose: add the leaf's bits one by one.
    always_comb begin
        leaf_cnt = '0;
        for (int i = 0; i < LEAF_SLOTS; i++) begin
            leaf_cnt = leaf_cnt + CW'(bits_in[i]);
        end
    end

    // Purpose: check leaf range and the all-ones corner.
    always_comb begin
        if (!$isunknown(bits_in)) begin
            a_r8_leaf_range: assert (leaf_cnt <= CW'(LEAF_SLOTS))
                else $error("leaf count out of range");
            a_r8_leaf_full: assert ((leaf_cnt == CW'(LEAF_SLOTS)) == (&bits_in))
                else $error("leaf full disagrees with bits");
        end
    end

endmodule

// File: rtl/occ_adder_tree.sv
// Module occ_adder_tree
// Sums NUM_LEAVES partial counts in a balanced binary tree.
// Assumes: leaves are padded with zero up to the next power of two.
module occ_adder_tree #(
    parameter int NUM_LEAVES = 10,
    parameter int IN_W       = 3,
    parameter int OUT_W      = 6,
    parameter int MAX_TOTAL  = 40
) (
    input  logic [NUM_LEAVES*IN_W-1:0] leaf_flat,
    output logic [OUT_W-1:0]           total
);

    localparam int DEPTH = (NUM_LEAVES > 1) ? $clog2(NUM_LEAVES) : 1;
    localparam int P2    = 1 << DEPTH;
    localparam int NODES = 2 * P2 - 1;

    logic [OUT_W-1:0] node [NODES];

    // Leaf slots of the tree: real counts, then zero padding.
    for (genvar k = 0; k < P2; k++) begin : g_leaf
        if (k < NUM_LEAVES) begin : g_real
            assign node[P2 - 1 + k] = OUT_W'(leaf_flat[k*IN_W +: IN_W]);
        end else begin : g_pad
            assign node[P2 - 1 + k] = '0;
        end
    end

    // Inner nodes: each is the sum of its two children.
    for (genvar n = 0; n < P2 - 1; n++) begin : g_node
        assign node[n] = node[2*n + 1] + node[2*n + 2];
    end

    assign total = node[0];

    // Purpose: the root never exceeds the slot count.
    always_comb begin
        if (!$isunknown(leaf_flat)) begin
            a_r8_total_bound: assert (total <= OUT_W'(MAX_TOTAL))
                else $error("tree total exceeds slot count");
        end
    end

endmodule

// File: rtl/occ_bin2bcd.sv
// Module occ_bin2bcd
// Splits a binary value 0..MAX_VAL into BCD tens and units digits.
// Assumes: MAX_VAL < 100, so two digits suffice.
module occ_bin2bcd
    import occ_pkg::*;
#(
    parameter int IN_W    = 6,
    parameter int MAX_VAL = 40,
    localparam int MAX_TENS = MAX_VAL / 10
) (
    input  logic [IN_W-1:0] value,
    output bcd_digit_t      tens,
    output bcd_digit_t      units
);

    logic [IN_W-1:0] rem;

    // Purpose: pick the largest multiple of ten not above the value.
    always_comb begin
        tens = '0;
        rem  = value;
        for (int k = 1; k <= MAX_TENS; k++) begin
            if (value >= IN_W'(10 * k)) begin
                tens = BCD_W'(k);
                rem  = value - IN_W'(10 * k);
            end
        end
        units = BCD_W'(rem);
    end

    // Purpose: the digits must rebuild the value and stay decimal.
    always_comb begin
        if (!$isunknown(value) && value <= IN_W'(MAX_VAL)) begin
            a_r6_digits_rebuild: assert ((32'(tens) * 10 + 32'(units)) == 32'(value))
                else $error("digits do not rebuild value");
            a_r6_units_decimal: assert (units <= 4'd9)
                else $error("units digit above nine");
            a_r5_tens_range: assert (32'(tens) <= MAX_TENS)
                else $error("tens digit out of range");
        end
    end

endmodule

// File: rtl/occ_slot_counter.sv
// Module occ_slot_counter
// Counts occupied slots, gives binary and BCD totals and a full flag.
// Assumes: NUM_SLOTS is a multiple of LEAF_SLOTS and below 100.
module occ_slot_counter
    import occ_pkg::*;
#(
    parameter int NUM_SLOTS  = 40,
    parameter int LEAF_SLOTS = 4,
    localparam int NUM_LEAVES = NUM_SLOTS / LEAF_SLOTS,
    localparam int LEAF_CW    = $clog2(LEAF_SLOTS + 1),
    localparam int CNT_W      = $clog2(NUM_SLOTS + 1)
) (
    input  logic [NUM_SLOTS-1:0] slot_occ,
    output logic [CNT_W-1:0]     occ_count,
    output logic [3:0]           occ_tens,
    output logic [3:0]           occ_units,
    output logic                 lot_full
);

    logic [NUM_LEAVES*LEAF_CW-1:0] leaf_flat;
    bcd_digit_t                    tens_d;
    bcd_digit_t                    units_d;

    // One counting leaf per group of LEAF_SLOTS slots.
    for (genvar g = 0; g < NUM_LEAVES; g++) begin : g_leaves
        occ_leaf_count #(
            .LEAF_SLOTS (LEAF_SLOTS)
        ) leaf_i (
            .bits_in  (slot_occ[g*LEAF_SLOTS +: LEAF_SLOTS]),
            .leaf_cnt (leaf_flat[g*LEAF_CW +: LEAF_CW])
        );
    end

    occ_adder_tree #(
        .NUM_LEAVES (NUM_LEAVES),
        .IN_W       (LEAF_CW),
        .OUT_W      (CNT_W),
        .MAX_TOTAL  (NUM_SLOTS)
    ) tree_i (
        .leaf_flat (leaf_flat),
        .total     (occ_count)
    );

    occ_bin2bcd #(
        .IN_W    (CNT_W),
        .MAX_VAL (NUM_SLOTS)
    ) bcd_i (
        .value (occ_count),
        .tens  (tens_d),
        .units (units_d)
    );

    assign occ_tens  = tens_d;
    assign occ_units = units_d;

    // Full flag taken from the arithmetic total.
    assign lot_full = (occ_count == CNT_W'(NUM_SLOTS));

    // Purpose: the total-based flag must agree with an AND of all inputs.
    always_comb begin
        if (!$isunknown(slot_occ)) begin
            a_r3_full_agree: assert (lot_full == (&slot_occ))
                else $error("full flag disagrees with input AND");
            a_r4_empty_zero: assert ((|slot_occ) || (occ_count == '0 && !lot_full))
                else $error("empty lot not reported as zero");
        end
    end

endmodule

// File: tb/occ_slot_counter_tb_top.sv
// Bench occ_slot_counter_tb_top
// Drives occupancy patterns and compares every output with a popcount.
module occ_slot_counter_tb_top;

    localparam int N = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] slot_occ = '0;
    logic [5:0]   occ_count;
    logic [3:0]   occ_tens;
    logic [3:0]   occ_units;
    logic         lot_full;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    occ_slot_counter dut_i (
        .slot_occ  (slot_occ),
        .occ_count (occ_count),
        .occ_tens  (occ_tens),
        .occ_units (occ_units),
        .lot_full  (lot_full)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int popcnt(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    // Apply a pattern on the falling edge, sample 1 ns later.
    task automatic apply_check(input logic [N-1:0] v, input string tag);
        int exp_c;
        @(negedge clk);
        slot_occ = v;
        #1;
        exp_c = popcnt(v);
        n_tests++;
        if (int'(occ_count) != exp_c) begin
            n_fail++;
            $display("FAIL %s R2 count: actual %0d expected %0d", tag, occ_count, exp_c);
        end
        n_tests++;
        if (lot_full != (exp_c == N)) begin
            n_fail++;
            $display("FAIL %s R3 full: actual %0b expected %0b", tag, lot_full, exp_c == N);
        end
        n_tests++;
        if (int'(occ_tens) != exp_c / 10) begin
            n_fail++;
            $display("FAIL %s R5 tens: actual %0d expected %0d", tag, occ_tens, exp_c / 10);
        end
        n_tests++;
        if (int'(occ_units) != exp_c % 10) begin
            n_fail++;
            $display("FAIL %s R6 units: actual %0d expected %0d", tag, occ_units, exp_c % 10);
        end
    endtask

    initial begin
        logic [N-1:0] v;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R4: empty lot gives zero everywhere.
        apply_check('0, "R4 empty");
        // R3: every slot taken.
        apply_check('1, "R3 all_full");

        // R1: one occupied slot at each position.
        for (int i = 0; i < N; i++) apply_check(N'(1) << i, "R1 single");

        // R3: one free slot at each position, flag must stay low.
        for (int i = 0; i < N; i++) apply_check(~(N'(1) << i), "R3 one_free");

        // R5/R6: thermometer fill through every count 0..40.
        for (int k = 0; k <= N; k++) begin
            v = (k == N) ? '1 : ((N'(1) << k) - N'(1));
            apply_check(v, "R5 R6 thermo");
        end

        // R8: each leaf full on its own.
        for (int g = 0; g < N / 4; g++) apply_check(N'(4'hF) << (4 * g), "R8 leaf_full");

        // R7: back-to-back changes, each sampled in the same period.
        for (int r = 0; r < 1500; r++) begin
            v = {$urandom, $urandom};
            apply_check(v, "R7 R2 uniform");
        end
        for (int r = 0; r < 500; r++) begin
            v = {$urandom, $urandom} & {$urandom, $urandom};
            apply_check(v, "R2 sparse");
        end
        for (int r = 0; r < 500; r++) begin
            v = {$urandom, $urandom} | {$urandom, $urandom} | {$urandom, $urandom};
            apply_check(v, "R2 dense");
        end

        // R4: return to empty after activity.
        apply_check('0, "R4 empty_again");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule